// File: doc/BRIEF.md
# Two-Stage 32-to-1 Serializer with Loopback Steering

This block turns a 32-bit parallel word into a single serial stream that runs 32 times faster than the word rate. The whole block runs on one fast bit clock. A two-stage divider (by 4, then by 8) gives a quarter-rate tick and a word-rate clock. Upstream logic uses the word-rate clock to launch the next parallel word.

The first stage has four 8-bit shift lanes. All four are parallel-loaded together by a load pulse that a small synchronization stage makes. After the load, each lane shifts once per quarter-rate tick. The second stage is a tree of 2:1 selectors. It interleaves the four lane outputs, first into two half-rate streams and then into the full-rate stream. The interleave puts the word on the line from bit 31 down to bit 0.

Two phase-select pins place the load pulse at one of four offsets within the word period. This lets the capture instant be moved relative to the moment the upstream logic launches the data. An active-low mode pin sends the stream and its clock to a loopback port instead of the normal port. The port not in use is held low. A frame marker goes high on the bit that carries bit 31.

Top module: `ser32_top`

## Requirements
- R1: While the synchronous reset is high, and after reset until the first load pulse, `norm_dat`, `loop_dat` and `frame_mark` are 0. `word_clk` is 1 during reset.
- R2: `word_clk` has a period of 32 bit-clock cycles. It is high for 16 cycles, starting at the cycle where the internal 5-bit cycle count is 0, and low for the next 16 cycles.
- R3: The load pulse falls at offset `8*{~ph_sel_hi, ~ph_sel_lo}` bit cycles after the word-clock rise. Both pins high gives offset 0. `ph_sel_hi`=1 with `ph_sel_lo`=0 gives 8. `ph_sel_hi`=0 with `ph_sel_lo`=1 gives 16. Both low gives 24. There is exactly one load pulse per word period.
- R4: Lane k (k=0..3) holds bits 31-k, 27-k, ..., 3-k, the highest first. The selected output carries `din[31]` first and `din[0]` last, one bit per bit-clock cycle, with no gap.
- R5: `frame_mark` is 1 for exactly the one cycle in which the serial output carries `din[31]`. That cycle is 2 bit cycles after the load pulse, so it comes offset+2 cycles after the word-clock rise.
- R6: Each serialized word is the `din` value present in its load cycle. Consecutive words follow each other without a gap, so a new marker comes 32 cycles after the previous one.
- R7: While `loop_n` is 0, the stream appears on `loop_dat` and the bit clock on `loop_clk`. While `loop_n` is 1, they appear on `norm_dat` and `norm_clk`. The data routing follows `loop_n` one cycle later.
- R8: The port not selected by `loop_n` has its data and its clock held at 0.
- R9: A change of `din` outside the load cycle has no effect on the word that is being serialized.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast bit clock |
| rst | input | 1 | Synchronous reset, active high |
| din | input | 32 | Parallel word; bit 31 is sent first |
| ph_sel_hi | input | 1 | Load-phase select, upper bit (inverted) |
| ph_sel_lo | input | 1 | Load-phase select, lower bit (inverted) |
| loop_n | input | 1 | 0 selects the loopback port, 1 selects the normal port |
| word_clk | output | 1 | Word-rate clock, bit clock divided by 32 |
| norm_dat | output | 1 | Serial data, normal port |
| norm_clk | output | 1 | Bit clock, normal port, low when not selected |
| loop_dat | output | 1 | Serial data, loopback port |
| loop_clk | output | 1 | Bit clock, loopback port, low when not selected |
| frame_mark | output | 1 | High on the bit that carries din[31] |

## Verification
The assertions assume a stable synchronous reset at the start, so that the divider and the lanes begin from zero. They relate the marker only to the load pulse that comes two cycles earlier. They also assume that the phase-select pins never change so fast that two loads fall into adjacent cycles.

The stimulus respects these assumptions. It changes `din`, the phase selects and `loop_n` only on the falling clock edge. After every phase or mode change it waits at least one full word period before it takes a word. Mid-period changes of `din` are made only right after a marker, so that they land away from the next load cycle.

// File: rtl/ser32_pkg.sv
`timescale 1ns/1ps
package ser32_pkg;
    localparam int LANES_DEF  = 4;
    localparam int LANE_W_DEF = 8;
    localparam int PHASES     = 4;
endpackage

// File: rtl/ser32_clkdiv.sv
`timescale 1ns/1ps
module ser32_clkdiv #(
    parameter int LANES  = ser32_pkg::LANES_DEF,
    parameter int LANE_W = ser32_pkg::LANE_W_DEF,
    localparam int QW    = $clog2(LANES),
    localparam int LW    = $clog2(LANE_W),
    localparam int CW    = QW + LW
) (
    input  logic          clk,
    input  logic          rst,
    output logic [CW-1:0] cnt,
    output logic          q_tick,
    output logic          word_clk
);
    typedef struct packed {
        logic [LW-1:0] oct;
        logic [QW-1:0] qtr;
    } div_t;

    div_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.qtr = st_q.qtr + 1'b1;
        if (st_q.qtr == '1) begin
            st_d.oct = st_q.oct + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign cnt      = {st_q.oct, st_q.qtr};
    assign q_tick   = (st_q.qtr == '0);
    assign word_clk = ~st_q.oct[LW-1];

    // R2: the word clock rises only after the last octet slot of a period
    assert_wclk_rise_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(word_clk) |-> (cnt == '0));
    // R2: the word clock falls in the middle of the period
    assert_wclk_fall_R2: assert property (@(posedge clk) disable iff (rst)
        $fell(word_clk) |-> (cnt == CW'(LANES * LANE_W / 2)));
endmodule

// File: rtl/ser32_loadsync.sv
`timescale 1ns/1ps
module ser32_loadsync #(
    parameter int LANES  = ser32_pkg::LANES_DEF,
    parameter int LANE_W = ser32_pkg::LANE_W_DEF,
    localparam int CW    = $clog2(LANES) + $clog2(LANE_W),
    localparam int STEP  = (LANES * LANE_W) / ser32_pkg::PHASES
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [CW-1:0] cnt,
    input  logic          q_tick,
    input  logic          ph_sel_hi,
    input  logic          ph_sel_lo,
    output logic          load
);
    logic [1:0]    idx;
    logic [CW-1:0] off;

    always_comb begin
        idx  = {~ph_sel_hi, ~ph_sel_lo};
        off  = CW'(int'(idx) * STEP);
        load = (cnt == off);
    end

    // R3: a load only lands on a quarter-rate boundary
    assert_load_quarter_R3: assert property (@(posedge clk) disable iff (rst)
        load |-> q_tick);
    // R3: a load pulse lasts a single bit cycle
    assert_load_single_R3: assert property (@(posedge clk) disable iff (rst)
        load |=> !load);
endmodule

// File: rtl/ser32_lane.sv
`timescale 1ns/1ps
module ser32_lane #(
    parameter int LANES  = ser32_pkg::LANES_DEF,
    parameter int LANE_W = ser32_pkg::LANE_W_DEF,
    parameter int IDX    = 0,
    localparam int WW    = LANES * LANE_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [WW-1:0] din,
    input  logic          load,
    input  logic          shift,
    output logic          msb
);
    logic [LANE_W-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        if (load) begin
            for (int p = 0; p < LANE_W; p++) begin
                sh_d[p] = din[LANES * p + LANES - 1 - IDX];
            end
        end else if (shift) begin
            sh_d = {sh_q[LANE_W-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) sh_q <= '0;
        else     sh_q <= sh_d;
    end

    assign msb = sh_q[LANE_W-1];

    // R9: outside load and shift slots the lane keeps its content
    assert_lane_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (!load && !shift) |=> (msb == $past(msb)));
endmodule

// File: rtl/ser32_seltree.sv
`timescale 1ns/1ps
module ser32_seltree #(
    parameter int N   = ser32_pkg::LANES_DEF,
    localparam int LG = $clog2(N)
) (
    input  logic [N-1:0]  bits,
    input  logic [LG-1:0] sel,
    output logic          y
);
    always_comb begin
        logic [N-1:0] cur;
        cur = bits;
        for (int l = 0; l < LG; l++) begin
            for (int j = 0; j < N; j++) begin
                if (j < (N >> (l + 1))) begin
                    cur[j] = sel[LG-1-l] ? cur[j + (N >> (l + 1))] : cur[j];
                end else begin
                    cur[j] = 1'b0;
                end
            end
        end
        y = cur[0];
    end
endmodule

// File: rtl/ser32_top.sv
`timescale 1ns/1ps
module ser32_top #(
    parameter int LANES  = ser32_pkg::LANES_DEF,
    parameter int LANE_W = ser32_pkg::LANE_W_DEF,
    localparam int WW    = LANES * LANE_W,
    localparam int QW    = $clog2(LANES),
    localparam int CW    = QW + $clog2(LANE_W)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [WW-1:0] din,
    input  logic          ph_sel_hi,
    input  logic          ph_sel_lo,
    input  logic          loop_n,
    output logic          word_clk,
    output logic          norm_dat,
    output logic          norm_clk,
    output logic          loop_dat,
    output logic          loop_clk,
    output logic          frame_mark
);
    typedef struct packed {
        logic ld1;
        logic loaded;
        logic mode;
        logic norm;
        logic loop;
        logic mark;
    } out_t;

    logic [CW-1:0]    cnt;
    logic             q_tick;
    logic             load;
    logic [LANES-1:0] msbs;
    logic [QW-1:0]    slot;
    logic             tree_bit;
    out_t             st_d, st_q;

    ser32_clkdiv #(.LANES(LANES), .LANE_W(LANE_W)) u_div (
        .clk(clk), .rst(rst), .cnt(cnt), .q_tick(q_tick), .word_clk(word_clk));

    ser32_loadsync #(.LANES(LANES), .LANE_W(LANE_W)) u_sync (
        .clk(clk), .rst(rst), .cnt(cnt), .q_tick(q_tick),
        .ph_sel_hi(ph_sel_hi), .ph_sel_lo(ph_sel_lo), .load(load));

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        ser32_lane #(.LANES(LANES), .LANE_W(LANE_W), .IDX(k)) u_lane (
            .clk(clk), .rst(rst), .din(din), .load(load),
            .shift(q_tick), .msb(msbs[k]));
    end

    // slot 0 is the cycle right after a quarter boundary
    assign slot = cnt[QW-1:0] - 1'b1;

    ser32_seltree #(.N(LANES)) u_tree (.bits(msbs), .sel(slot), .y(tree_bit));

    always_comb begin
        st_d        = st_q;
        st_d.ld1    = load;
        st_d.loaded = st_q.loaded | load;
        st_d.mode   = loop_n;
        st_d.norm   = loop_n & tree_bit;
        st_d.loop   = ~loop_n & tree_bit;
        st_d.mark   = st_q.ld1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= '0;
            st_q.mode <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign norm_dat   = st_q.norm;
    assign loop_dat   = st_q.loop;
    assign frame_mark = st_q.mark;
    assign norm_clk   = clk & st_q.mode;
    assign loop_clk   = clk & ~st_q.mode;

    // R1: no data leaves before the first word has been loaded
    assert_quiet_before_load_R1: assert property (@(posedge clk) disable iff (rst)
        !st_q.loaded |-> (!norm_dat && !loop_dat && !frame_mark));
    // R5: the marker trails the load pulse by two bit cycles
    assert_mark_after_load_R5: assert property (@(posedge clk) disable iff (rst)
        frame_mark |-> $past(load, 2));
    // R7: at most one data port is active
    assert_one_port_R7: assert property (@(posedge clk) disable iff (rst)
        $onehot0({norm_dat, loop_dat}));
    // R8: the normal port stays low while loopback was selected
    assert_idle_normal_R8: assert property (@(posedge clk) disable iff (rst)
        !$past(loop_n) |-> !norm_dat);
    // R8: the loopback port stays low while normal output was selected
    assert_idle_loop_R8: assert property (@(posedge clk) disable iff (rst)
        $past(loop_n) |-> !loop_dat);
endmodule

// File: tb/tb_ser32_top.sv
`timescale 1ns/1ps
module tb_ser32_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] din = '1;
    logic        ph_sel_hi = 1'b0;
    logic        ph_sel_lo = 1'b0;
    logic        loop_n = 1'b1;
    logic        word_clk, norm_dat, norm_clk, loop_dat, loop_clk, frame_mark;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    ser32_top dut (
        .clk(clk), .rst(rst), .din(din), .ph_sel_hi(ph_sel_hi),
        .ph_sel_lo(ph_sel_lo), .loop_n(loop_n), .word_clk(word_clk),
        .norm_dat(norm_dat), .norm_clk(norm_clk), .loop_dat(loop_dat),
        .loop_clk(loop_clk), .frame_mark(frame_mark));

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wait_mark(input string tag);
        int k = 0;
        while (!frame_mark && k < 70) begin
            @(negedge clk);
            k++;
        end
        chk(frame_mark == 1'b1, tag, frame_mark, 1);
    endtask

    // called at a negedge where frame_mark is high
    task automatic grab(input bit use_loop, output logic [31:0] w, output int idle_bad);
        idle_bad = 0;
        w[31] = use_loop ? loop_dat : norm_dat;
        if ((use_loop ? norm_dat : loop_dat) !== 1'b0) idle_bad++;
        for (int j = 30; j >= 0; j--) begin
            @(negedge clk);
            w[j] = use_loop ? loop_dat : norm_dat;
            if ((use_loop ? norm_dat : loop_dat) !== 1'b0) idle_bad++;
            if (frame_mark !== 1'b0) idle_bad++;
        end
    endtask

    task automatic t_reset();
        cyc(3);
        chk(norm_dat == 0 && loop_dat == 0 && frame_mark == 0, "R1 data low in reset",
            {norm_dat, loop_dat, frame_mark}, 0);
        chk(word_clk == 1'b1, "R1 word clock high in reset", word_clk, 1);
    endtask

    task automatic t_pre_load();
        int bad = 0;
        rst = 1'b0;
        for (int i = 0; i < 24; i++) begin
            @(negedge clk);
            if (norm_dat || loop_dat || frame_mark) bad++;
        end
        chk(bad == 0, "R1 silent before first load", bad, 0);
    endtask

    task automatic find_rise();
        logic prev;
        prev = word_clk;
        @(negedge clk);
        while (!(word_clk && !prev)) begin
            prev = word_clk;
            @(negedge clk);
        end
    endtask

    task automatic t_wclk();
        int hi = 0;
        int lo = 0;
        find_rise();
        while (word_clk) begin hi++; @(negedge clk); end
        while (!word_clk) begin lo++; @(negedge clk); end
        chk(hi == 16, "R2 word clock high time", hi, 16);
        chk(lo == 16, "R2 word clock low time", lo, 16);
    endtask

    task automatic t_phase(input logic h, input logic l, input int off);
        int k = 0;
        ph_sel_hi = h;
        ph_sel_lo = l;
        cyc(64);
        find_rise();
        while (!frame_mark && k < 40) begin
            @(negedge clk);
            k++;
        end
        chk(k == off + 2, "R3 R5 marker offset from word clock rise", k, off + 2);
    endtask

    task automatic t_word(input logic [31:0] w, input string tag);
        logic [31:0] got;
        int bad;
        din = w;
        cyc(34);
        wait_mark({tag, " marker"});
        grab(1'b0, got, bad);
        chk(got == w, tag, got, w);
        chk(bad == 0, "R5 single marker per word", bad, 0);
    endtask

    task automatic t_stream();
        logic [31:0] a, b;
        int bad;
        din = 32'hC3A5_0F96;
        cyc(34);
        wait_mark("R6 marker");
        a[31] = norm_dat;
        din = 32'h1234_5678;   // mid-word change
        grab(1'b0, b, bad);
        b[31] = a[31];
        chk(b == 32'hC3A5_0F96, "R9 mid-word din change ignored", b, 32'hC3A5_0F96);
        @(negedge clk);
        chk(frame_mark == 1'b1, "R6 next marker after 32 cycles", frame_mark, 1);
        grab(1'b0, a, bad);
        chk(a == 32'h1234_5678, "R6 back-to-back second word", a, 32'h1234_5678);
    endtask

    task automatic t_loop();
        logic [31:0] got;
        int bad;
        loop_n = 1'b0;
        din = 32'h5A5A_F00D;
        cyc(34);
        wait_mark("R7 loop marker");
        grab(1'b1, got, bad);
        chk(got == 32'h5A5A_F00D, "R7 word on loopback port", got, 32'h5A5A_F00D);
        chk(bad == 0, "R8 normal data idle in loopback", bad, 0);
        @(posedge clk);
        #1;
        chk(loop_clk == 1'b1, "R7 loopback clock runs", loop_clk, 1);
        chk(norm_clk == 1'b0, "R8 normal clock idle", norm_clk, 0);
        @(negedge clk);
        loop_n = 1'b1;
        din = 32'hFFFF_0001;
        cyc(34);
        wait_mark("R7 normal marker");
        grab(1'b0, got, bad);
        chk(got == 32'hFFFF_0001, "R7 word back on normal port", got, 32'hFFFF_0001);
        chk(bad == 0, "R8 loopback data idle in normal mode", bad, 0);
        @(posedge clk);
        #1;
        chk(norm_clk == 1'b1, "R7 normal clock runs", norm_clk, 1);
        chk(loop_clk == 1'b0, "R8 loopback clock idle", loop_clk, 0);
        @(negedge clk);
    endtask

    initial begin
        t_reset();
        t_pre_load();
        t_wclk();
        t_phase(1'b0, 1'b0, 24);
        t_phase(1'b1, 1'b1, 0);
        t_phase(1'b1, 1'b0, 8);
        t_phase(1'b0, 1'b1, 16);
        t_word(32'h8000_0001, "R4 order end bits");
        t_word(32'h0123_4567, "R4 order counting nibbles");
        t_word(32'h8888_8888, "R4 lane0 only");
        t_word(32'h1111_1111, "R4 lane3 only");
        t_stream();
        t_loop();
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule